// File: doc/BRIEF.md
# Packed Halfword Dot-Product Accumulator

This block multiplies two pairs of signed 16-bit lanes and folds both products into one of four 64-bit accumulators, which it holds along with a sticky overflow flag for each. The first operand and the second operand each carry two lanes, with the low lane in bits 15:0 and the high lane in bits 31:16. A 5-bit operation code picks the lane pairing (straight or crossed), whether the products are added to or subtracted from the accumulator, whether the products are plain integers or Q15 fractions, and whether the accumulator is clamped to the signed 32-bit range.

An operation is presented with a one-cycle valid strobe, and it updates the selected accumulator at that clock edge. A small test port lets a bench or a neighbour preset either 32-bit half of any accumulator and read it back combinationally. The overflow flags appear as a 4-bit vector in which bit i belongs to accumulator i.

Top module: `dotmac_unit`

## Requirements
- R1: After reset, all four accumulators read zero and all four overflow flags are zero.
- R2: Op code 00000 adds a_lo*b_lo + a_hi*b_hi, signed 16x16 products, to the accumulator chosen by acc_sel.
- R3: Op codes 00001 (straight) and 01001 (crossed) subtract both products from the chosen accumulator instead of adding them.
- R4: Op code 01000 uses the crossed pairing a_lo*b_hi + a_hi*b_lo and adds the result.
- R5: Op codes 11000 (add) and 11001 (subtract) use the crossed pairing, double each product, and accumulate over the full 64 bits with no clamping.
- R6: In the fractional codes, a pair whose two lanes are both 0x8000 contributes 0x7FFFFFFF in place of its product and sets the chosen accumulator's flag.
- R7: Op codes 11010 (add) and 11011 (subtract) act like 11000 and 11001, but a result above 0x7FFFFFFF or below 0xFFFFFFFF80000000 is replaced by that bound, and ovf_flags bit acc_sel is set.
- R8: Flags are sticky: an operation that neither saturates nor hits the special case leaves every flag as it was, and a set flag stays set until reset.
- R9: Only the selected accumulator changes. The new value can be read on the test port after the clock edge that samples the strobe. Integer accumulation wraps modulo 2^64.
- R10: A valid strobe with any op code not listed in R2 to R7 changes no accumulator and no flag.
- R11: With op_valid low, tp_wr writes tp_wdata into the high word (tp_hi=1) or the low word (tp_hi=0) of accumulator tp_sel. tp_rdata always shows that word. While op_valid is high, tp_wr is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 5 | Operation selector |
| acc_sel | input | 2 | Target accumulator |
| op_a | input | 32 | First operand, two signed lanes |
| op_b | input | 32 | Second operand, two signed lanes |
| tp_wr | input | 1 | Test-port write enable |
| tp_sel | input | 2 | Test-port accumulator index |
| tp_hi | input | 1 | Test-port word select, 1 = high word |
| tp_wdata | input | 32 | Test-port write data |
| tp_rdata | output | 32 | Test-port read data |
| ovf_flags | output | 4 | Sticky overflow flag for each accumulator |

## Verification
The operands are chosen with unequal lane products, so that straight and crossed pairings give different sums and a swapped pairing shows up. Mixed-sign lanes separate signed products from unsigned ones, and add and subtract results are checked on their own. Fractional operands are pushed just past the 32-bit bounds in both directions, with and without clamping, which separates doubling, clamping and flag setting. Further cases cover the 0x8000 pair, a 64-bit wrap, unlisted codes, and a test-port write that collides with an operation.

// File: rtl/dotmac_unit.sv
module dotmac_unit #(
  parameter int LANE_W  = 16,
  parameter int NUM_ACC = 4,
  localparam int WORD_W = 2 * LANE_W,
  localparam int ACC_W  = 2 * WORD_W,
  localparam int IDX_W  = $clog2(NUM_ACC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [4:0]        op_code,
  input  logic [IDX_W-1:0]  acc_sel,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              tp_wr,
  input  logic [IDX_W-1:0]  tp_sel,
  input  logic              tp_hi,
  input  logic [WORD_W-1:0] tp_wdata,
  output logic [WORD_W-1:0] tp_rdata,
  output logic [NUM_ACC-1:0] ovf_flags
);

  localparam logic [LANE_W-1:0]       LANE_MIN = {1'b1, {(LANE_W-1){1'b0}}};
  localparam logic signed [WORD_W-1:0] WORD_MAX = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0]  SAT_HI   = {{WORD_W{1'b0}}, 1'b0, {(WORD_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0]  SAT_LO   = {{(WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};

  logic [ACC_W-1:0]   acc_q [NUM_ACC];
  logic [NUM_ACC-1:0] flags_q;

  logic is_sub, is_cross, is_frac, is_sat, code_ok;
  assign is_sub   = op_code[0];
  assign is_sat   = op_code[1];
  assign is_cross = op_code[3];
  assign is_frac  = op_code[4];

  always_comb begin
    case (op_code)
      5'b00000, 5'b00001, 5'b01000, 5'b01001,
      5'b11000, 5'b11001, 5'b11010, 5'b11011: code_ok = 1'b1;
      default:                                 code_ok = 1'b0;
    endcase
  end

  logic signed [LANE_W-1:0] a_lo, a_hi, m0_b, m1_b;
  assign a_lo = op_a[LANE_W-1:0];
  assign a_hi = op_a[WORD_W-1:LANE_W];
  assign m0_b = is_cross ? op_b[WORD_W-1:LANE_W] : op_b[LANE_W-1:0];
  assign m1_b = is_cross ? op_b[LANE_W-1:0]      : op_b[WORD_W-1:LANE_W];

  logic signed [WORD_W-1:0] raw0, raw1, term0, term1;
  logic spec0, spec1;
  assign raw0  = a_lo * m0_b;
  assign raw1  = a_hi * m1_b;
  assign spec0 = is_frac && (a_lo == LANE_MIN) && (m0_b == LANE_MIN);
  assign spec1 = is_frac && (a_hi == LANE_MIN) && (m1_b == LANE_MIN);
  assign term0 = spec0 ? WORD_MAX : (is_frac ? (raw0 <<< 1) : raw0);
  assign term1 = spec1 ? WORD_MAX : (is_frac ? (raw1 <<< 1) : raw1);

  logic signed [ACC_W-1:0] cur, ext0, ext1, sum, next_val;
  logic above, below, sat_hit, flag_set;
  assign cur  = acc_q[acc_sel];
  assign ext0 = {{WORD_W{term0[WORD_W-1]}}, term0};
  assign ext1 = {{WORD_W{term1[WORD_W-1]}}, term1};
  assign sum  = is_sub ? (cur - ext0 - ext1) : (cur + ext0 + ext1);

  assign above    = is_sat && (sum > SAT_HI);
  assign below    = is_sat && (sum < SAT_LO);
  assign sat_hit  = above || below;
  assign next_val = above ? SAT_HI : (below ? SAT_LO : sum);
  assign flag_set = spec0 || spec1 || sat_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ACC; i++) acc_q[i] <= '0;
      flags_q <= '0;
    end else if (op_valid) begin
      if (code_ok) begin
        acc_q[acc_sel] <= next_val;
        if (flag_set) flags_q[acc_sel] <= 1'b1;
      end
    end else if (tp_wr) begin
      if (tp_hi) acc_q[tp_sel][ACC_W-1:WORD_W] <= tp_wdata;
      else       acc_q[tp_sel][WORD_W-1:0]     <= tp_wdata;
    end
  end

  assign tp_rdata  = tp_hi ? acc_q[tp_sel][ACC_W-1:WORD_W] : acc_q[tp_sel][WORD_W-1:0];
  assign ovf_flags = flags_q;

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags))); // R8

  AST_BAD_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !code_ok) |=> ($stable(ovf_flags) && acc_q[$past(acc_sel)] == $past(acc_q[acc_sel]))); // R10

  AST_SAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && code_ok && is_sat) |=>
      ($signed(acc_q[$past(acc_sel)]) <= SAT_HI && $signed(acc_q[$past(acc_sel)]) >= SAT_LO)); // R7

  AST_SAT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && code_ok && sat_hit) |=> ovf_flags[$past(acc_sel)]); // R7

  AST_SPECIAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && code_ok && (spec0 || spec1)) |=> ovf_flags[$past(acc_sel)]); // R6

  AST_TP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && tp_wr && tp_sel != acc_sel) |=> acc_q[$past(tp_sel)] == $past(acc_q[tp_sel])); // R11

endmodule

// File: tb/dotmac_unit_test.sv
`timescale 1ns/1ps
module dotmac_unit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, tp_wr = 1'b0, tp_hi = 1'b0;
  logic [4:0] op_code = '0;
  logic [1:0] acc_sel = '0, tp_sel = '0;
  logic [31:0] op_a = '0, op_b = '0, tp_wdata = '0, tp_rdata;
  logic [3:0] ovf_flags;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dotmac_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .acc_sel(acc_sel),
    .op_a(op_a), .op_b(op_b), .tp_wr(tp_wr), .tp_sel(tp_sel), .tp_hi(tp_hi),
    .tp_wdata(tp_wdata), .tp_rdata(tp_rdata), .ovf_flags(ovf_flags)
  );

  task automatic chk64(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s acc got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic chkf(input string req, input logic [3:0] exp);
    checks++;
    if (ovf_flags !== exp) begin
      failures++;
      $display("FAIL %s flags got=%b exp=%b", req, ovf_flags, exp);
    end
  endtask

  task automatic rd_acc(input logic [1:0] idx, output logic [63:0] v);
    tp_sel = idx; tp_hi = 1'b0; #0.5; v[31:0] = tp_rdata;
    tp_hi = 1'b1; #0.5; v[63:32] = tp_rdata;
  endtask

  task automatic wr_acc(input logic [1:0] idx, input logic [63:0] v);
    @(negedge clk); tp_wr = 1'b1; tp_sel = idx; tp_hi = 1'b0; tp_wdata = v[31:0];
    @(negedge clk); tp_hi = 1'b1; tp_wdata = v[63:32];
    @(negedge clk); tp_wr = 1'b0;
  endtask

  task automatic do_op(input logic [4:0] code, input logic [1:0] idx, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk); op_valid = 1'b1; op_code = code; acc_sel = idx; op_a = a; op_b = b;
    @(negedge clk); op_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [63:0] v;
    for (int i = 0; i < 4; i++) begin rd_acc(2'(i), v); chk64("R1 reset", v, 64'd0); end
    chkf("R1 reset", 4'b0000);
  endtask

  task automatic t_straight;
    logic [63:0] v;
    wr_acc(2'd1, 64'd10);
    do_op(5'b00000, 2'd1, 32'h0003_FFFE, 32'h0005_0007);
    rd_acc(2'd1, v); chk64("R2 straight add", v, 64'd11);
    rd_acc(2'd0, v); chk64("R9 others untouched", v, 64'd0);
    rd_acc(2'd3, v); chk64("R9 others untouched", v, 64'd0);
  endtask

  task automatic t_sub;
    logic [63:0] v;
    do_op(5'b00001, 2'd2, 32'h0003_FFFE, 32'h0005_0007);
    rd_acc(2'd2, v); chk64("R3 straight sub", v, 64'hFFFF_FFFF_FFFF_FFFF);
    do_op(5'b01001, 2'd2, 32'h0002_0003, 32'h0004_0005);
    rd_acc(2'd2, v); chk64("R3 crossed sub", v, 64'hFFFF_FFFF_FFFF_FFE9);
  endtask

  task automatic t_cross;
    logic [63:0] v;
    do_op(5'b01000, 2'd3, 32'h0002_0003, 32'h0004_0005);
    rd_acc(2'd3, v); chk64("R4 crossed add", v, 64'd22);
  endtask

  task automatic t_frac;
    logic [63:0] v;
    wr_acc(2'd0, 64'h0000_0001_0000_0000);
    do_op(5'b11000, 2'd0, 32'h4000_2000, 32'h1000_0800);
    rd_acc(2'd0, v); chk64("R5 frac add", v, 64'h0000_0001_0800_0000);
    wr_acc(2'd0, 64'h0000_0000_7FFF_FFF0);
    do_op(5'b11000, 2'd0, 32'h0000_0010, 32'h0001_0000);
    rd_acc(2'd0, v); chk64("R5 no clamp", v, 64'h0000_0000_8000_0010);
    do_op(5'b11001, 2'd0, 32'h0000_0010, 32'h0001_0000);
    rd_acc(2'd0, v); chk64("R5 frac sub", v, 64'h0000_0000_7FFF_FFF0);
    chkf("R8 no flag when in range", 4'b0000);
  endtask

  task automatic t_special;
    logic [63:0] v;
    wr_acc(2'd3, 64'd0);
    do_op(5'b11000, 2'd3, 32'h0001_8000, 32'h8000_0001);
    rd_acc(2'd3, v); chk64("R6 special product", v, 64'h0000_0000_8000_0001);
    chkf("R6 special flag", 4'b1000);
  endtask

  task automatic t_sat;
    logic [63:0] v;
    wr_acc(2'd2, 64'h0000_0000_7FFF_FFF0);
    do_op(5'b11010, 2'd2, 32'h0000_0010, 32'h0001_0000);
    rd_acc(2'd2, v); chk64("R7 clamp high", v, 64'h0000_0000_7FFF_FFFF);
    chkf("R7 flag high", 4'b1100);
    wr_acc(2'd1, 64'hFFFF_FFFF_8000_0005);
    do_op(5'b11011, 2'd1, 32'h0000_0010, 32'h0001_0000);
    rd_acc(2'd1, v); chk64("R7 clamp low", v, 64'hFFFF_FFFF_8000_0000);
    chkf("R7 flag low", 4'b1110);
    wr_acc(2'd0, 64'd100);
    do_op(5'b11010, 2'd0, 32'h0000_0010, 32'h0001_0000);
    rd_acc(2'd0, v); chk64("R7 in range kept", v, 64'd132);
    chkf("R8 flag0 untouched", 4'b1110);
  endtask

  task automatic t_sticky;
    logic [63:0] v;
    wr_acc(2'd2, 64'd0);
    do_op(5'b11010, 2'd2, 32'h0000_0010, 32'h0001_0000);
    rd_acc(2'd2, v); chk64("R8 in-range after flag", v, 64'd32);
    chkf("R8 sticky", 4'b1110);
  endtask

  task automatic t_badcode;
    logic [63:0] v;
    wr_acc(2'd0, 64'd5);
    do_op(5'b00010, 2'd0, 32'h8000_8000, 32'h8000_8000);
    rd_acc(2'd0, v); chk64("R10 bad code 00010", v, 64'd5);
    do_op(5'b10000, 2'd0, 32'h0001_0001, 32'h0001_0001);
    rd_acc(2'd0, v); chk64("R10 bad code 10000", v, 64'd5);
    chkf("R10 flags unchanged", 4'b1110);
  endtask

  task automatic t_wrap;
    logic [63:0] v;
    wr_acc(2'd3, 64'h7FFF_FFFF_FFFF_FFFF);
    do_op(5'b00000, 2'd3, 32'h0000_0001, 32'h0000_0001);
    rd_acc(2'd3, v); chk64("R9 wrap", v, 64'h8000_0000_0000_0000);
  endtask

  task automatic t_collide;
    logic [63:0] v;
    wr_acc(2'd0, 64'd0);
    wr_acc(2'd1, 64'd7);
    @(negedge clk);
    op_valid = 1'b1; op_code = 5'b00000; acc_sel = 2'd0; op_a = 32'h1; op_b = 32'h1;
    tp_wr = 1'b1; tp_sel = 2'd1; tp_hi = 1'b0; tp_wdata = 32'hDEAD;
    @(negedge clk); op_valid = 1'b0; tp_wr = 1'b0;
    rd_acc(2'd0, v); chk64("R11 op wins", v, 64'd1);
    rd_acc(2'd1, v); chk64("R11 write ignored", v, 64'd7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_straight();
    t_sub();
    t_cross();
    t_frac();
    t_special();
    t_sat();
    t_sticky();
    t_badcode();
    t_wrap();
    t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule